// File: doc/BRIEF.md
# Debug-Port Sequential Read Responder

This block sits on the target side of a two-wire debug port. The host owns the port clock, and the single data line changes direction during a transfer. The block watches for a 2-bit sequential-read command. When that command arrives, it freezes the current 32-bit visibility register into a shadow buffer. It then returns the frozen value to the host, least significant bit first, one bit per host clock.

While those bits leave, the block makes a single read on a synchronous memory port at the address held in an internal pointer. It writes the returned word back into the visibility register and advances the pointer by one word. A host that issues the command again and again therefore receives consecutive memory words, and it needs no extra clocks between commands.

The host clock and data input are sampled by the system clock through a synchronizer, and all logic runs on the system clock. The host clock must therefore be several times slower than the system clock.

Top module: `dbgSeqReadPort`

## Requirements
- R1: After reset the data output enable is low, no memory request is raised, the visibility register holds `VIS_INIT` and the pointer holds `PTR_INIT`.
- R2: Command bits are taken on synchronized rising edges of the host clock. Two bits both equal to 1 start a sequential read. Any other 2-bit code (00, 01, 10) drives nothing, issues no memory read, leaves the visibility register and the pointer unchanged, and the next host clock starts a new command.
- R3: The output enable stays low through the rising edge of the idle clock that follows the command. It goes high on the falling edge of that idle clock, and bit 0 is then on the data output.
- R4: The 32 returned bits come least significant bit first. Bit i+1 replaces bit i on the falling edge of the host clock whose rising edge let the host sample bit i. The word returned is the visibility register content as it stood when the command was decoded, before any reload.
- R5: Each accepted command raises exactly one single-cycle memory request at the current pointer. The pointer then advances by 4 and wraps modulo 2^24.
- R6: The read data, which arrives one system cycle after the request, replaces the visibility register. This happens long before the last bit leaves, so a command issued straight after the trailing idle clock returns that word.
- R7: The output enable falls on the falling edge that ends the bit-31 transfer. One further idle host clock completes the command, and the following host clock is taken as a new command bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock for all logic and the memory port |
| rstN | input | 1 | Asynchronous active-low reset |
| dbgClk | input | 1 | Host-driven debug port clock |
| dbgDataIn | input | 1 | Data line as seen from the host |
| dbgDataOut | output | 1 | Data bit driven toward the host |
| dbgDataOe | output | 1 | High while the target owns the data line |
| memReq | output | 1 | Single-cycle memory read request |
| memAddr | output | 24 | Read address, valid with memReq |
| memRdData | input | 32 | Read data, valid one cycle after memReq |

## Verification
The bench drives a long stream of back-to-back reads with the pointer starting just below the top of the address space. A design that reloaded before snapshotting would return memory data on the first command instead of the initial register value. Missing wrap logic would produce a wrong address. A design that pre-incremented the pointer would read one word ahead. The bench sweeps every 2-bit code between valid reads. A decoder that accepted a wrong code, drove the line, or disturbed the register or pointer shows up as an output-enable pulse, a stray request, or a break in the word stream. The bench also watches the output enable just before and just after the idle clock edges, which catches a turnaround one edge early or late.

// File: rtl/dbgSeqPkg.sv
package dbgSeqPkg;

  typedef struct packed {
    logic snap;   // freeze visibility register and launch the memory read
    logic shift;  // advance the shadow buffer by one bit
  } seqStrobeT;

  typedef enum logic [1:0] {
    ST_WAIT,
    ST_TURN_IN,
    ST_SEND,
    ST_TURN_OUT
  } seqStateT;

endpackage

// File: rtl/dbgEdgeSync.sv
module dbgEdgeSync #(
  parameter int STAGES = 2
) (
  input  logic sysClk,
  input  logic rstN,
  input  logic dbgClk,
  input  logic dbgDataIn,
  output logic hostRise,
  output logic hostFall,
  output logic hostBit
);

  logic [STAGES-1:0] clkPipe;
  logic [STAGES-1:0] dataPipe;
  logic              clkPrev;

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      clkPipe  <= '0;
      dataPipe <= '0;
      clkPrev  <= 1'b0;
    end else begin
      clkPipe  <= {clkPipe[STAGES-2:0], dbgClk};
      dataPipe <= {dataPipe[STAGES-2:0], dbgDataIn};
      clkPrev  <= clkPipe[STAGES-1];
    end
  end

  assign hostRise = clkPipe[STAGES-1] & ~clkPrev;
  assign hostFall = ~clkPipe[STAGES-1] & clkPrev;
  assign hostBit  = dataPipe[STAGES-1];

  a_r2_edges_exclusive: assert property (@(posedge sysClk) disable iff (!rstN)
    !(hostRise && hostFall));

endmodule

// File: rtl/seqRdCtrl.sv
module seqRdCtrl
  import dbgSeqPkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          CMD_W    = 2,
  parameter logic [CMD_W-1:0] CMD_CODE = '1
) (
  input  logic      sysClk,
  input  logic      rstN,
  input  logic      hostRise,
  input  logic      hostFall,
  input  logic      hostBit,
  output seqStrobeT strb,
  output logic      driveEn
);

  localparam int BIT_W     = $clog2(DATA_W);
  localparam int CMD_CNT_W = (CMD_W > 1) ? $clog2(CMD_W) : 1;

  seqStateT             state;
  logic [CMD_W-1:0]     cmdSh;
  logic [CMD_W-1:0]     cmdNext;
  logic [CMD_CNT_W-1:0] cmdCnt;
  logic [BIT_W-1:0]     bitIdx;
  logic                 seenRise;
  logic                 lastCmdBit;
  logic                 lastDataBit;

  assign cmdNext     = (cmdSh << 1) | CMD_W'(hostBit);
  assign lastCmdBit  = (cmdCnt == CMD_CNT_W'(CMD_W - 1));
  assign lastDataBit = (bitIdx == BIT_W'(DATA_W - 1));

  always_comb begin
    strb       = '0;
    strb.snap  = (state == ST_WAIT) && hostRise && lastCmdBit && (cmdNext == CMD_CODE);
    strb.shift = (state == ST_SEND) && hostFall && !lastDataBit;
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_WAIT;
      cmdSh    <= '0;
      cmdCnt   <= '0;
      bitIdx   <= '0;
      seenRise <= 1'b0;
      driveEn  <= 1'b0;
    end else begin
      case (state)
        ST_WAIT: begin
          if (hostRise) begin
            if (lastCmdBit) begin
              cmdSh  <= '0;
              cmdCnt <= '0;
              if (cmdNext == CMD_CODE) begin
                state    <= ST_TURN_IN;
                seenRise <= 1'b0;
              end
            end else begin
              cmdSh  <= cmdNext;
              cmdCnt <= cmdCnt + 1'b1;
            end
          end
        end
        ST_TURN_IN: begin
          if (hostRise) seenRise <= 1'b1;
          if (hostFall && seenRise) begin
            driveEn <= 1'b1;
            bitIdx  <= '0;
            state   <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (hostFall) begin
            if (lastDataBit) begin
              driveEn  <= 1'b0;
              seenRise <= 1'b0;
              state    <= ST_TURN_OUT;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end
        end
        ST_TURN_OUT: begin
          if (hostRise) seenRise <= 1'b1;
          if (hostFall && seenRise) begin
            seenRise <= 1'b0;
            state    <= ST_WAIT;
          end
        end
        default: state <= ST_WAIT;
      endcase
    end
  end

  a_r3_drive_on_fall: assert property (@(posedge sysClk) disable iff (!rstN)
    $rose(driveEn) |-> $past(hostFall));

  a_r7_release_on_fall: assert property (@(posedge sysClk) disable iff (!rstN)
    $fell(driveEn) |-> $past(hostFall));

  a_r4_shift_while_driving: assert property (@(posedge sysClk) disable iff (!rstN)
    strb.shift |-> driveEn);

  a_r2_snap_when_idle: assert property (@(posedge sysClk) disable iff (!rstN)
    strb.snap |-> !driveEn);

endmodule

// File: rtl/seqRdDatapath.sv
module seqRdDatapath
  import dbgSeqPkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter int                ADDR_W    = 24,
  parameter int                ADDR_STEP = 4,
  parameter logic [DATA_W-1:0] VIS_INIT  = '0,
  parameter logic [ADDR_W-1:0] PTR_INIT  = '0
) (
  input  logic              sysClk,
  input  logic              rstN,
  input  seqStrobeT         strb,
  output logic              dataBit,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdData
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(ADDR_STEP);

  logic [DATA_W-1:0] visReg;
  logic [DATA_W-1:0] shadow;
  logic [ADDR_W-1:0] ptr;
  logic              rdPend;

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      shadow <= '0;
    end else if (strb.snap) begin
      shadow <= visReg;
    end else if (strb.shift) begin
      shadow <= shadow >> 1;
    end
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      ptr     <= PTR_INIT;
      memReq  <= 1'b0;
      memAddr <= '0;
      rdPend  <= 1'b0;
      visReg  <= VIS_INIT;
    end else begin
      memReq <= strb.snap;
      rdPend <= memReq;
      if (strb.snap) begin
        memAddr <= ptr;
        ptr     <= ptr + STEP;
      end
      if (rdPend) visReg <= memRdData;
    end
  end

  assign dataBit = shadow[0];

  a_r5_single_cycle_req: assert property (@(posedge sysClk) disable iff (!rstN)
    memReq |=> !memReq);

  a_r5_ptr_step: assert property (@(posedge sysClk) disable iff (!rstN)
    (ptr != $past(ptr)) |-> (ptr == $past(ptr) + STEP));

  a_r4_shadow_hold: assert property (@(posedge sysClk) disable iff (!rstN)
    (!strb.snap && !strb.shift) |=> $stable(shadow));

  a_r6_reload_after_req: assert property (@(posedge sysClk) disable iff (!rstN)
    (visReg != $past(visReg)) |-> $past(memReq, 2));

endmodule

// File: rtl/dbgSeqReadPort.sv
module dbgSeqReadPort
  import dbgSeqPkg::*;
#(
  parameter int                DATA_W      = 32,
  parameter int                ADDR_W      = 24,
  parameter int                ADDR_STEP   = 4,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] VIS_INIT    = '0,
  parameter logic [ADDR_W-1:0] PTR_INIT    = '0
) (
  input  logic              sysClk,
  input  logic              rstN,
  input  logic              dbgClk,
  input  logic              dbgDataIn,
  output logic              dbgDataOut,
  output logic              dbgDataOe,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdData
);

  logic      hostRise;
  logic      hostFall;
  logic      hostBit;
  seqStrobeT strb;

  dbgEdgeSync #(.STAGES(SYNC_STAGES)) uSync (
    .sysClk   (sysClk),
    .rstN     (rstN),
    .dbgClk   (dbgClk),
    .dbgDataIn(dbgDataIn),
    .hostRise (hostRise),
    .hostFall (hostFall),
    .hostBit  (hostBit)
  );

  seqRdCtrl #(.DATA_W(DATA_W), .CMD_W(2), .CMD_CODE(2'b11)) uCtrl (
    .sysClk  (sysClk),
    .rstN    (rstN),
    .hostRise(hostRise),
    .hostFall(hostFall),
    .hostBit (hostBit),
    .strb    (strb),
    .driveEn (dbgDataOe)
  );

  seqRdDatapath #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .ADDR_STEP(ADDR_STEP),
    .VIS_INIT (VIS_INIT),
    .PTR_INIT (PTR_INIT)
  ) uData (
    .sysClk   (sysClk),
    .rstN     (rstN),
    .strb     (strb),
    .dataBit  (dbgDataOut),
    .memReq   (memReq),
    .memAddr  (memAddr),
    .memRdData(memRdData)
  );

endmodule

// File: tb/tb_dbgSeqReadPort.sv
module tb_dbgSeqReadPort;

  localparam int          HALF     = 8;
  localparam logic [31:0] VIS0     = 32'h1234_5678;
  localparam logic [23:0] PTR0     = 24'hFF_FFF0;
  localparam int          WD_LIMIT = 150000;

  logic        sysClk = 1'b0;
  logic        rstN = 1'b0;
  logic        dbgClk = 1'b0;
  logic        dbgDataIn = 1'b0;
  logic        dbgDataOut;
  logic        dbgDataOe;
  logic        memReq;
  logic [23:0] memAddr;
  logic [31:0] memRdData = '0;

  int          checks = 0;
  int          errors = 0;
  int          reqCount = 0;
  int          oeCycles = 0;
  int          wdCount = 0;
  logic [23:0] lastAddr = '0;
  logic [31:0] expVis = VIS0;
  logic [23:0] expPtr = PTR0;

  always #4 sysClk = ~sysClk;

  dbgSeqReadPort #(.VIS_INIT(VIS0), .PTR_INIT(PTR0)) dut (
    .sysClk, .rstN, .dbgClk, .dbgDataIn, .dbgDataOut, .dbgDataOe,
    .memReq, .memAddr, .memRdData
  );

  function automatic logic [31:0] memFn(logic [23:0] a);
    return ({8'h00, a} * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  always @(posedge sysClk) begin
    if (memReq) begin
      memRdData <= memFn(memAddr);
      lastAddr  <= memAddr;
      reqCount  <= reqCount + 1;
    end
    if (dbgDataOe) oeCycles <= oeCycles + 1;
  end

  always @(posedge sysClk) begin
    wdCount <= wdCount + 1;
    if (wdCount == WD_LIMIT) begin
      $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", wdCount, WD_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic halfWait();
    repeat (HALF) @(negedge sysClk);
  endtask

  task automatic pulse();
    dbgClk = 1'b1;
    halfWait();
    dbgClk = 1'b0;
    halfWait();
  endtask

  // one complete accepted read: command, idle, 32 bits, trailing idle
  task automatic runRead();
    int          startReq;
    logic [31:0] got;
    bit          oeGap;
    startReq = reqCount;
    got      = '0;
    oeGap    = 1'b0;
    dbgDataIn = 1'b1; pulse();
    dbgDataIn = 1'b1; pulse();
    dbgDataIn = 1'b0;
    dbgClk = 1'b1;
    halfWait();
    check(dbgDataOe == 1'b0, "R3 enable low before idle fall", 32'(dbgDataOe), 32'd0);
    dbgClk = 1'b0;
    halfWait();
    check(dbgDataOe == 1'b1, "R3 enable high after idle fall", 32'(dbgDataOe), 32'd1);
    for (int i = 0; i < 32; i++) begin
      got[i] = dbgDataOut;
      if (!dbgDataOe) oeGap = 1'b1;
      pulse();
    end
    check(!oeGap, "R4 enable held through 32 bits", 32'(oeGap), 32'd0);
    check(dbgDataOe == 1'b0, "R7 released after bit-31 fall", 32'(dbgDataOe), 32'd0);
    check(got == expVis, "R4/R6 returned word", got, expVis);
    check(reqCount == startReq + 1, "R5 one request per command", 32'(reqCount - startReq), 32'd1);
    check(lastAddr == expPtr, "R5 request address", 32'(lastAddr), 32'(expPtr));
    expVis = memFn(expPtr);
    expPtr = expPtr + 24'd4;
    pulse();
  endtask

  // a command code that must be ignored (R2)
  task automatic runBad(input logic b1, input logic b0);
    int startReq;
    int startOe;
    startReq = reqCount;
    startOe  = oeCycles;
    dbgDataIn = b1; pulse();
    dbgDataIn = b0; pulse();
    dbgDataIn = 1'b0;
    halfWait();
    check(oeCycles == startOe, "R2 ignored code never drives", 32'(oeCycles - startOe), 32'd0);
    check(reqCount == startReq, "R2 ignored code no read", 32'(reqCount - startReq), 32'd0);
  endtask

  initial begin
    repeat (5) @(negedge sysClk);
    check(dbgDataOe == 1'b0, "R1 reset enable", 32'(dbgDataOe), 32'd0);
    check(memReq == 1'b0, "R1 reset request", 32'(memReq), 32'd0);
    rstN = 1'b1;
    repeat (5) @(negedge sysClk);
    check(reqCount == 0, "R1 no request after reset", 32'(reqCount), 32'd0);
    // first word is the reset value of the register; pointer wraps within six reads
    for (int n = 0; n < 6; n++) runRead();
    // every ignored code, each followed by a valid read continuing the stream
    for (int c = 0; c < 3; c++) begin
      runBad(c[1], c[0]);
      runRead();
    end
    runBad(1'b0, 1'b1);
    runBad(1'b1, 1'b0);
    for (int n = 0; n < 4; n++) runRead();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule